// File: doc/BRIEF.md
# Conversion Start Controller

This block decides the clock cycle in which an analog-to-digital conversion begins. Software owns a small control register with five fields: converter enable, start bit, auto-trigger enable, a 3-bit trigger select and a flag-clear bit. Every register write updates all fields at once. A conversion can begin in three ways: software writes one to the start bit, a hardware source selected by the trigger field shows a rising edge, or the previous conversion completes while free-running operation is selected.

The converter is modelled as a counter. It advances on an ADC clock tick, which a prescaler produces once every `PRESC_DIV` system clocks. A conversion ends on its `CONV_TICKS`-th tick, and at that edge the busy bit drops and the completion flag rises. The prescaler is held at zero while the converter is disabled. It starts counting on the edge that sets the enable, so tick edges fall at multiples of `PRESC_DIV` clocks after that edge. The sampling and approximation arithmetic and the result storage belong to neighbouring blocks.

Top module: `convStartUnit`

## Requirements
- R1: After reset, `convStart`, `busy` and `irqFlag` are all 0.
- R2: A write with `wrEnable`=1 and `wrStart`=1 while no conversion is running pulses `convStart` high for exactly one cycle following that write edge, and `busy` reads 1 from that cycle on.
- R3: `busy` stays 1 for the whole conversion, whatever started it. The conversion ends on the `CONV_TICKS`-th (default 13) ADC tick edge after the start edge. Tick edges fall every `PRESC_DIV` (default 4) clocks counted from the edge that set the enable. On the end edge `busy` goes to 0 and `irqFlag` to 1.
- R4: With auto-trigger on and trigger select k in 1..7, a conversion starts on the edge that first samples `trigSrc[k-1]` high after it was low. A source held high starts nothing more, and unselected sources have no effect.
- R5: A trigger edge or a start write that arrives while a conversion is running is dropped and not queued.
- R6: Trigger select 0 with auto-trigger on selects free running. Nothing starts until software writes the start bit. After that, each completion starts the next conversion on the same edge, whether or not `irqFlag` was cleared.
- R7: While `ampChannel` is 1, free running is refused: a completion under select 0 does not start another conversion.
- R8: A write with `wrFlagClr`=1 clears `irqFlag`. When it coincides with a completion edge, the flag stays 1.
- R9: A write with `wrStart`=0 starts nothing.
- R10: A write with `wrEnable`=0 aborts a running conversion: `busy` is 0 after that edge and no completion follows. No start is accepted while the enable is 0.
- R11: With auto-trigger on and a hardware source selected, a start-bit write still starts a single conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Control register write strobe |
| wrEnable | input | 1 | Converter enable field |
| wrStart | input | 1 | Start bit field; one requests a conversion |
| wrAutoEn | input | 1 | Auto-trigger enable field |
| wrTrigSel | input | 3 | Trigger select; 0 = completion event, k = trigSrc[k-1] |
| wrFlagClr | input | 1 | Writing one clears the completion flag |
| trigSrc | input | NUM_SRC | Hardware trigger sources |
| ampChannel | input | 1 | Selected channel is an amplified one |
| convStart | output | 1 | One-cycle start pulse to the conversion engine |
| busy | output | 1 | Start bit read-back; 1 while converting |
| irqFlag | output | 1 | Conversion-complete flag |

## Verification
The bench aims at the edges where the causes of a start meet. These are a trigger edge during a running conversion (a queuing design would start a second conversion late), a trigger held high (a level-sensitive design would restart endlessly) and a flag clear landing on the completion edge (a design that lets the clear win would lose an interrupt). It runs several back-to-back free-running conversions without ever clearing the flag, so a design that keys the restart off the flag level would stall after the first. It also checks that select 0 with the amplifier set ends after one conversion. Finally it aborts a free-running conversion by dropping the enable, so any further start pulse or late completion shows up as an unexpected event in the scoreboard.

// File: rtl/convStartPkg.sv
`timescale 1ns/1ps
package convStartPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic runPresc;  // prescaler counts while set, held at zero otherwise
    logic loadCnt;   // restart the conversion counter this edge
    logic busy;      // a conversion is running
  } ctlStrobe_t;
endpackage

// File: rtl/convStartPath.sv
`timescale 1ns/1ps
module convStartPath
  import convStartPkg::*;
#(
  parameter int NUM_SRC    = 7,
  parameter int PRESC_DIV  = 4,
  parameter int CONV_TICKS = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [NUM_SRC-1:0] trigSrc,
  output logic [NUM_SRC-1:0] srcRise,
  output logic               convDone
);
  localparam int PW = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;
  localparam int CW = (CONV_TICKS > 2) ? $clog2(CONV_TICKS) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(PRESC_DIV - 1);
  localparam logic [CW-1:0] CNT_LAST   = CW'(CONV_TICKS - 1);

  logic [PW-1:0] presc;
  logic [CW-1:0] tickCnt;
  logic          adcTick;

  // prescaler: held in reset while the converter is off
  always_ff @(posedge clk) begin
    if (!rstN || !strb.runPresc) presc <= '0;
    else if (presc == PRESC_LAST) presc <= '0;
    else presc <= presc + 1'b1;
  end

  assign adcTick = strb.runPresc && (presc == PRESC_LAST);

  // conversion length counter
  always_ff @(posedge clk) begin
    if (!rstN) tickCnt <= '0;
    else if (strb.loadCnt) tickCnt <= '0;
    else if (strb.busy && adcTick) tickCnt <= (tickCnt == CNT_LAST) ? '0 : tickCnt + 1'b1;
  end

  assign convDone = strb.busy && adcTick && (tickCnt == CNT_LAST);

  // one rising-edge detector per source
  for (genvar i = 0; i < NUM_SRC; i++) begin : gEdge
    logic prevSrc;
    always_ff @(posedge clk) begin
      if (!rstN) prevSrc <= 1'b0;
      else prevSrc <= trigSrc[i];
    end
    assign srcRise[i] = trigSrc[i] & ~prevSrc;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CNT_LAST); // R3
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.runPresc |-> !convDone); // R10
endmodule

// File: rtl/convStartFsm.sv
`timescale 1ns/1ps
module convStartFsm
  import convStartPkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrite,
  input  logic               wrEnable,
  input  logic               wrStart,
  input  logic               wrAutoEn,
  input  logic [SEL_W-1:0]   wrTrigSel,
  input  logic               wrFlagClr,
  input  logic               ampChannel,
  input  logic [NUM_SRC-1:0] srcRise,
  input  logic               convDone,
  output ctlStrobe_t         strb,
  output logic               startPulse,
  output logic               busyReg,
  output logic               flagReg
);
  logic             enableReg;
  logic             autoEn;
  logic [SEL_W-1:0] trigSel;
  logic             hwRise;
  logic             swStart;
  logic             hwStart;
  logic             restart;
  logic             abortNow;
  logic             startNow;

  always_comb begin
    hwRise = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (trigSel == SEL_W'(i + 1)) hwRise = hwRise | srcRise[i];
    end
  end

  assign abortNow = regWrite && !wrEnable;
  assign swStart  = regWrite && wrStart && wrEnable;
  assign hwStart  = enableReg && autoEn && (trigSel != '0) && hwRise;
  assign restart  = convDone && autoEn && (trigSel == '0) && !ampChannel;
  assign startNow = !abortNow && ((!busyReg && (swStart || hwStart)) || restart);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg  <= 1'b0;
      autoEn     <= 1'b0;
      trigSel    <= '0;
      busyReg    <= 1'b0;
      flagReg    <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      if (regWrite) begin
        enableReg <= wrEnable;
        autoEn    <= wrAutoEn;
        trigSel   <= wrTrigSel;
      end
      startPulse <= startNow;
      if (abortNow) busyReg <= 1'b0;
      else if (startNow) busyReg <= 1'b1;
      else if (convDone) busyReg <= 1'b0;
      // completion outranks a same-cycle clear
      if (convDone && !abortNow) flagReg <= 1'b1;
      else if (regWrite && wrFlagClr) flagReg <= 1'b0;
    end
  end

  assign strb.runPresc = enableReg;
  assign strb.loadCnt  = startNow;
  assign strb.busy     = busyReg;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> busyReg); // R3
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !abortNow) |=> flagReg); // R8
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enableReg |-> !busyReg); // R10
  AST_AMP_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && ampChannel) |=> !busyReg); // R7
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && autoEn && trigSel == '0 && !ampChannel && !abortNow) |=> startPulse); // R6
endmodule

// File: rtl/convStartUnit.sv
`timescale 1ns/1ps
module convStartUnit
  import convStartPkg::*;
#(
  parameter int NUM_SRC    = 7,
  parameter int PRESC_DIV  = 4,
  parameter int CONV_TICKS = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrite,
  input  logic               wrEnable,
  input  logic               wrStart,
  input  logic               wrAutoEn,
  input  logic [2:0]         wrTrigSel,
  input  logic               wrFlagClr,
  input  logic [NUM_SRC-1:0] trigSrc,
  input  logic               ampChannel,
  output logic               convStart,
  output logic               busy,
  output logic               irqFlag
);
  ctlStrobe_t         strb;
  logic [NUM_SRC-1:0] srcRise;
  logic               convDone;

  convStartFsm #(.NUM_SRC(NUM_SRC), .SEL_W(3)) uFsm (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .wrEnable(wrEnable),
    .wrStart(wrStart), .wrAutoEn(wrAutoEn), .wrTrigSel(wrTrigSel),
    .wrFlagClr(wrFlagClr), .ampChannel(ampChannel), .srcRise(srcRise),
    .convDone(convDone), .strb(strb), .startPulse(convStart),
    .busyReg(busy), .flagReg(irqFlag)
  );

  convStartPath #(.NUM_SRC(NUM_SRC), .PRESC_DIV(PRESC_DIV), .CONV_TICKS(CONV_TICKS)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .trigSrc(trigSrc),
    .srcRise(srcRise), .convDone(convDone)
  );
endmodule

// File: tb/convStartUnit_test.sv
`timescale 1ns/1ps
module convStartUnit_test;
  localparam int DIV  = 4;
  localparam int CONV = 13;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrite = 1'b0, wrEnable = 1'b0, wrStart = 1'b0, wrAutoEn = 1'b0, wrFlagClr = 1'b0;
  logic [2:0] wrTrigSel = 3'd0;
  logic [6:0] trigSrc = '0;
  logic       ampChannel = 1'b0;
  logic       convStart, busy, irqFlag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int enEdge = 0;
  int expCyc[$];
  string expTag[$];

  convStartUnit #(.NUM_SRC(7), .PRESC_DIV(DIV), .CONV_TICKS(CONV)) uut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .wrEnable(wrEnable),
    .wrStart(wrStart), .wrAutoEn(wrAutoEn), .wrTrigSel(wrTrigSel),
    .wrFlagClr(wrFlagClr), .trigSrc(trigSrc), .ampChannel(ampChannel),
    .convStart(convStart), .busy(busy), .irqFlag(irqFlag)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver: one register write, called at a falling edge
  task automatic wr(input logic en, input logic st, input logic au,
                    input logic [2:0] sel, input logic clr, output int edgeNo);
    regWrite = 1'b1; wrEnable = en; wrStart = st; wrAutoEn = au;
    wrTrigSel = sel; wrFlagClr = clr;
    edgeNo = cyc + 1;
    @(negedge clk);
    regWrite = 1'b0; wrStart = 1'b0; wrFlagClr = 1'b0;
  endtask

  task automatic expectStart(input int e, input string tag);
    expCyc.push_back(e);
    expTag.push_back(tag);
  endtask

  task automatic waitUntil(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  function automatic int doneEdge(input int s);
    return enEdge + DIV * ((s - enEdge) / DIV + 1) + (CONV - 1) * DIV;
  endfunction

  // monitor: every start pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (rstN && convStart) begin
      checks++;
      if (expCyc.size() == 0) begin
        errors++;
        $display("FAIL R5 start pulse at cycle %0d, expected none", cyc);
      end else begin
        int e;
        string t;
        e = expCyc.pop_front();
        t = expTag.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL %s start pulse actual cycle=%0d expected=%0d", t, cyc, e);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e, s, d, d1, d2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 convStart", convStart, 0);
    chk("R1 busy", busy, 0);
    chk("R1 irqFlag", irqFlag, 0);

    // start with enable low is refused
    wr(1'b0, 1'b1, 1'b0, 3'd0, 1'b0, e);
    repeat (3) @(negedge clk);
    chk("R10 start while disabled", busy, 0);

    // enable, then a zero start write
    wr(1'b1, 1'b0, 1'b0, 3'd0, 1'b0, e);
    enEdge = e;
    wr(1'b1, 1'b0, 1'b0, 3'd0, 1'b0, e);
    repeat (5) @(negedge clk);
    chk("R9 zero start", busy, 0);

    // software start
    s = cyc + 1;
    expectStart(s, "R2");
    wr(1'b1, 1'b1, 1'b0, 3'd0, 1'b0, e);
    chk("R2 busy after start", busy, 1);
    d = doneEdge(s);
    waitUntil(s + 10);
    wr(1'b1, 1'b1, 1'b0, 3'd0, 1'b0, e); // R5 start write while busy
    waitUntil(d - 1);
    chk("R3 busy before end", busy, 1);
    chk("R3 flag before end", irqFlag, 0);
    waitUntil(d);
    chk("R3 busy at end", busy, 0);
    chk("R3 flag at end", irqFlag, 1);

    wr(1'b1, 1'b0, 1'b0, 3'd0, 1'b1, e);
    chk("R8 flag cleared", irqFlag, 0);

    // hardware trigger on source index 1
    wr(1'b1, 1'b0, 1'b1, 3'd2, 1'b0, e);
    repeat (2) @(negedge clk);
    trigSrc[3] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 unselected source", busy, 0);
    trigSrc[3] = 1'b0;
    s = cyc + 1;
    expectStart(s, "R4");
    trigSrc[1] = 1'b1;
    @(negedge clk);
    chk("R4 busy after edge", busy, 1);
    d = doneEdge(s);
    waitUntil(s + 8);
    trigSrc[1] = 1'b0;
    @(negedge clk);
    trigSrc[1] = 1'b1; // R5 edge during conversion
    waitUntil(d - 1);
    wr(1'b1, 1'b0, 1'b1, 3'd2, 1'b1, e); // clear on completion edge
    chk("R8 completion beats clear", irqFlag, 1);
    chk("R3 busy after hw conversion", busy, 0);
    repeat (20) @(negedge clk);
    chk("R4 held level no restart", busy, 0);
    trigSrc[1] = 1'b0;
    @(negedge clk);

    // software start with auto-trigger on
    s = cyc + 1;
    expectStart(s, "R11");
    wr(1'b1, 1'b1, 1'b1, 3'd2, 1'b0, e);
    chk("R11 busy", busy, 1);
    waitUntil(doneEdge(s));
    chk("R11 done", busy, 0);
    wr(1'b1, 1'b0, 1'b1, 3'd2, 1'b1, e);

    // free running
    wr(1'b1, 1'b0, 1'b1, 3'd0, 1'b0, e);
    repeat (60) @(negedge clk);
    chk("R6 no start before software", busy, 0);
    s = cyc + 1;
    expectStart(s, "R6 first");
    wr(1'b1, 1'b1, 1'b1, 3'd0, 1'b0, e);
    d1 = doneEdge(s);
    d2 = d1 + DIV * CONV;
    expectStart(d1, "R6 restart1");
    expectStart(d2, "R6 restart2");
    waitUntil(d1);
    chk("R6 busy across restart", busy, 1);
    chk("R6 flag set uncleared", irqFlag, 1);
    waitUntil(d2);
    chk("R6 busy second restart", busy, 1);

    // abort by disabling
    waitUntil(d2 + 5);
    wr(1'b0, 1'b0, 1'b1, 3'd0, 1'b0, e);
    chk("R10 abort", busy, 0);
    repeat (70) @(negedge clk);
    chk("R10 stays idle", busy, 0);

    // amplified channel refuses free running
    ampChannel = 1'b1;
    wr(1'b1, 1'b0, 1'b1, 3'd0, 1'b1, e);
    enEdge = e;
    chk("R8 clear", irqFlag, 0);
    s = cyc + 1;
    expectStart(s, "R7 single");
    wr(1'b1, 1'b1, 1'b1, 3'd0, 1'b0, e);
    d = doneEdge(s);
    waitUntil(d);
    chk("R7 no restart busy", busy, 0);
    chk("R7 flag", irqFlag, 1);
    repeat (60) @(negedge clk);
    chk("R7 still idle", busy, 0);

    chk("R6 pending expected starts", expCyc.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule